// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block sits between a host and a 128K x 8 parallel EEPROM. It drives the memory's chip-enable, output-enable and write-enable strobes, a 17-bit address bus and a shared 8-bit data bus. It watches the memory's ready/busy line and drives its reset line. The host asks for one operation at a time with a level request and gets a one-cycle acknowledge back. An operation is either a single-byte read or a page write of 1 to 128 bytes. For a write, the controller fetches each byte from the host by index while it loads the page.

Every pulse width, gap and wait is a cycle count. Each count is worked out at elaboration from a clock-period parameter and a set of nanosecond limits, rounding up. After the last byte of a page, the controller lets the byte-load window lapse so that the memory begins its internal programming. It then finishes in one of two ways, chosen by a mode input: it watches ready/busy, or it waits a fixed programming time.

A write request whose bytes would run past the end of a 128-byte page is refused with an error flag and is never split. A zero-length write is refused the same way.

Top module: `eep_page_ctrl`

## Requirements
- R1: While `rst` is high, `mem_rst_n` is 0, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `ack` is 0. After `rst` falls, chip-enable stays high for at least the reset-recovery time (100 us) before any access.
- R2: A read (`req_write`=0) holds chip-enable and output-enable low for at least the access time (250 ns). It returns the byte at `req_addr` on `rd_data` and raises `ack` for exactly one cycle.
- R3: Write-enable and output-enable are never low together. The controller drives `mem_dq` only while write-enable is low or in the hold cycle after it.
- R4: Each write-enable low pulse lasts at least 250 ns, and chip-enable is low during the whole pulse.
- R5: Within one page write, the time between successive write-enable falling edges is at least 1 us and at most 30 us.
- R6: Within one page write, address bits 16..7 do not change. Byte k (counting from 0) is written at `req_addr` + k.
- R7: A write with `req_len` = 0, or with `req_addr[6:0]` + `req_len` > 128, is acknowledged with `err`=1 and causes no strobe. A write ending exactly at the page end is accepted.
- R8: With `use_rdy`=0, the write acknowledge comes no earlier than the programming time (parameter `T_WC_NS`) after the last write-enable rising edge.
- R9: With `use_rdy`=1, the write acknowledge comes only after `mem_rdy` has returned to 1 (1 = ready), and at least 250 ns after it returned.
- R10: Every byte the host supplies for index k holds on the data bus through the rising edge of write-enable. A later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_PERIOD_NS` |
| rst | input | 1 | Synchronous reset, active high |
| use_rdy | input | 1 | 1: end a write on ready/busy; 0: end it after a fixed time |
| req | input | 1 | Request, held until `ack` |
| req_write | input | 1 | 1 = page write, 0 = byte read |
| req_addr | input | 17 | Read address or first write address |
| req_len | input | 8 | Write length in bytes (1..128) |
| wr_idx | output | 7 | Index of the write byte the controller wants next |
| wr_byte | input | 8 | Host byte for `wr_idx`, valid in the same cycle |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | With `ack`: request refused |
| rd_data | output | 8 | Read result, valid from `ack` |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq | inout | 8 | Memory data bus |
| mem_rdy | input | 1 | Memory ready/busy, 1 = ready |
| mem_rst_n | output | 1 | Memory reset, active low |

## Verification
Some rules can be checked on every cycle, and the assertions do that: no bus overlap, the write-enable width, chip-enable framing each strobe, the byte-to-byte window, the fixed upper address bits, the quiet period after reset, refusals without strobes, and the acknowledge waiting for ready. Other results only show up in the bench's scenarios. These are that the right bytes reach the right addresses and read back intact, that the timeout mode really waits the programming time, and that the acknowledge in ready mode comes after the busy period of a memory model. They also include the page-edge cases: a full 128-byte page, a write ending exactly at the page end, and refused lengths.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        S_INIT,
        S_IDLE,
        S_RD_ACC,
        S_RD_FLT,
        S_WR_PREP,
        S_WR_LOW,
        S_WR_HOLD,
        S_WR_GAP,
        S_WR_SETTLE,
        S_WR_POLL,
        S_WR_TMO,
        S_WR_RECOV,
        S_DONE
    } eep_state_e;

    // Round a time in ns up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

endpackage

// File: rtl/eep_wait_timer.sv
module eep_wait_timer #(
    parameter int unsigned         CNT_W   = 32,
    parameter logic [CNT_W-1:0]    RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= RST_VAL;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/eep_req_check.sv
module eep_req_check #(
    parameter int unsigned PAGE_BYTES = 128,
    localparam int unsigned IDX_W     = $clog2(PAGE_BYTES),
    localparam int unsigned LEN_W     = IDX_W + 1
) (
    input  logic [IDX_W-1:0] start_low,
    input  logic [LEN_W-1:0] len,
    output logic             bad
);
    logic [LEN_W:0] end_pos;

    always_comb begin
        end_pos = {2'b00, start_low} + {1'b0, len};
        bad     = (len == '0) || (end_pos > (LEN_W+1)'(PAGE_BYTES));
    end
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
    import eep_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned PAGE_BYTES    = 128,
    parameter int unsigned T_WP_NS       = 250,
    parameter int unsigned T_DH_NS       = 10,
    parameter int unsigned T_BLC_NS      = 1000,
    parameter int unsigned T_BL_MAX_NS   = 30000,
    parameter int unsigned T_DB_NS       = 120,
    parameter int unsigned T_DW_NS       = 250,
    parameter int unsigned T_WC_NS       = 10000000,
    parameter int unsigned T_ACC_NS      = 250,
    parameter int unsigned T_DF_NS       = 50,
    parameter int unsigned T_RP_NS       = 100000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          use_rdy,
    input  logic                          req,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [$clog2(PAGE_BYTES):0]   req_len,
    output logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
    input  logic [DATA_W-1:0]             wr_byte,
    output logic                          ack,
    output logic                          err,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          mem_ce_n,
    output logic                          mem_oe_n,
    output logic                          mem_we_n,
    output logic [ADDR_W-1:0]             mem_addr,
    inout  wire  [DATA_W-1:0]             mem_dq,
    input  logic                          mem_rdy,
    output logic                          mem_rst_n
);
    localparam int unsigned IDX_W      = $clog2(PAGE_BYTES);
    localparam int unsigned LEN_W      = IDX_W + 1;
    localparam int unsigned WP_CYC     = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned DH_CYC     = ns_to_cyc(T_DH_NS, CLK_PERIOD_NS);
    localparam int unsigned BLC_CYC    = ns_to_cyc(T_BLC_NS, CLK_PERIOD_NS);
    localparam int unsigned BL_MAX_CYC = T_BL_MAX_NS / CLK_PERIOD_NS;
    localparam int unsigned GAP_CYC    = (BLC_CYC > WP_CYC + DH_CYC + 2)
                                         ? BLC_CYC - WP_CYC - DH_CYC - 1 : 1;
    localparam int unsigned SETTLE_CYC = ns_to_cyc(T_BL_MAX_NS + T_DB_NS, CLK_PERIOD_NS);
    localparam int unsigned DW_CYC     = ns_to_cyc(T_DW_NS, CLK_PERIOD_NS);
    localparam int unsigned WC_CYC     = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned ACC_CYC    = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS) + 1;
    localparam int unsigned DF_CYC     = ns_to_cyc(T_DF_NS, CLK_PERIOD_NS) + 1;
    localparam int unsigned RP_CYC     = ns_to_cyc(T_RP_NS, CLK_PERIOD_NS);

    typedef struct packed {
        eep_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] rdata;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  len;
        logic              err;
        logic              ack;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              rdy_s1;
        logic              rdy_s2;
        logic              rst_n;
    } ctrl_t;

    ctrl_t       q, n;
    logic        t_load, t_done, req_bad;
    logic [31:0] t_val;

    // Cycles spent in a state, minus one, loaded into the timer on entry.
    function automatic logic [31:0] state_len(input eep_state_e s);
        case (s)
            S_RD_ACC:    return 32'(ACC_CYC - 1);
            S_RD_FLT:    return 32'(DF_CYC - 1);
            S_WR_LOW:    return 32'(WP_CYC - 1);
            S_WR_HOLD:   return 32'(DH_CYC - 1);
            S_WR_GAP:    return 32'(GAP_CYC - 1);
            S_WR_SETTLE: return 32'(SETTLE_CYC - 1);
            S_WR_TMO:    return 32'(WC_CYC - 1);
            S_WR_RECOV:  return 32'(DW_CYC - 1);
            default:     return 32'd0;
        endcase
    endfunction

    eep_wait_timer #(
        .CNT_W   (32),
        .RST_VAL (32'(RP_CYC - 1))
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    eep_req_check #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_check (
        .start_low (req_addr[IDX_W-1:0]),
        .len       (req_len),
        .bad       (req_bad)
    );

    always_comb begin
        n        = q;
        n.ack    = 1'b0;
        n.rst_n  = 1'b1;
        n.rdy_s1 = mem_rdy;
        n.rdy_s2 = q.rdy_s1;
        unique case (q.st)
            S_INIT:    if (t_done) n.st = S_IDLE;
            S_IDLE: begin
                if (req) begin
                    n.addr = req_addr;
                    n.err  = 1'b0;
                    if (!req_write) begin
                        n.st = S_RD_ACC;
                    end else if (req_bad) begin
                        n.err = 1'b1;
                        n.st  = S_DONE;
                    end else begin
                        n.idx = '0;
                        n.len = req_len;
                        n.st  = S_WR_PREP;
                    end
                end
            end
            S_RD_ACC: begin
                if (t_done) begin
                    n.rdata = mem_dq;
                    n.st    = S_RD_FLT;
                end
            end
            S_RD_FLT:  if (t_done) n.st = S_DONE;
            S_WR_PREP: begin
                n.dout = wr_byte;
                n.st   = S_WR_LOW;
            end
            S_WR_LOW:  if (t_done) n.st = S_WR_HOLD;
            S_WR_HOLD: if (t_done) n.st = S_WR_GAP;
            S_WR_GAP: begin
                if (t_done) begin
                    if ({1'b0, q.idx} == q.len - 1'b1) begin
                        n.st = S_WR_SETTLE;
                    end else begin
                        n.idx  = q.idx + 1'b1;
                        n.addr = q.addr + 1'b1;
                        n.st   = S_WR_PREP;
                    end
                end
            end
            S_WR_SETTLE: if (t_done) n.st = use_rdy ? S_WR_POLL : S_WR_TMO;
            S_WR_POLL:   if (q.rdy_s2) n.st = S_WR_RECOV;
            S_WR_TMO:    if (t_done) n.st = S_DONE;
            S_WR_RECOV:  if (t_done) n.st = S_DONE;
            S_DONE:      n.st = S_IDLE;
            default:     n.st = S_IDLE;
        endcase

        t_load  = (n.st != q.st);
        t_val   = state_len(n.st);
        n.ack   = (n.st == S_DONE);
        n.ce_n  = !(n.st inside {S_RD_ACC, S_WR_PREP, S_WR_LOW, S_WR_HOLD, S_WR_GAP});
        n.oe_n  = (n.st != S_RD_ACC);
        n.we_n  = (n.st != S_WR_LOW);
        n.dq_oe = (n.st inside {S_WR_LOW, S_WR_HOLD});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.st     <= S_INIT;
            q.ce_n   <= 1'b1;
            q.oe_n   <= 1'b1;
            q.we_n   <= 1'b1;
            q.rst_n  <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign wr_idx    = q.idx;
    assign ack       = q.ack;
    assign err       = q.ack & q.err;
    assign rd_data   = q.rdata;
    assign mem_ce_n  = q.ce_n;
    assign mem_oe_n  = q.oe_n;
    assign mem_we_n  = q.we_n;
    assign mem_addr  = q.addr;
    assign mem_rst_n = q.rst_n;
    assign mem_dq    = q.dq_oe ? q.dout : 'z;
endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk #(
    parameter int unsigned ADDR_W     = 17,
    parameter int unsigned IDX_W      = 7,
    parameter int unsigned WP_CYC     = 25,
    parameter int unsigned BLC_CYC    = 100,
    parameter int unsigned BL_MAX_CYC = 3000,
    parameter int unsigned RP_CYC     = 10000
) (
    input logic              clk,
    input logic              rst,
    input logic              use_rdy,
    input logic              ack,
    input logic              err,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_rdy,
    input logic [ADDR_W-1:0] mem_addr
);
    logic                     we_d, seen_q, fell;
    int unsigned              lo_cnt, gap_cnt, since_rst;
    logic [ADDR_W-IDX_W-1:0]  page_q;

    assign fell = we_d && !mem_we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_d      <= 1'b1;
            seen_q    <= 1'b0;
            lo_cnt    <= 0;
            gap_cnt   <= 0;
            since_rst <= 0;
            page_q    <= '0;
        end else begin
            we_d   <= mem_we_n;
            lo_cnt <= mem_we_n ? 0 : lo_cnt + 1;
            if (fell)
                gap_cnt <= 1;
            else if (seen_q && gap_cnt <= BL_MAX_CYC)
                gap_cnt <= gap_cnt + 1;
            if (mem_ce_n)
                seen_q <= 1'b0;
            else if (fell)
                seen_q <= 1'b1;
            if (fell && !seen_q)
                page_q <= mem_addr[ADDR_W-1:IDX_W];
            if (since_rst < RP_CYC)
                since_rst <= since_rst + 1;
        end
    end

    assert_rst_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst < RP_CYC) |-> mem_ce_n);
    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);
    assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we_n && !we_d) |-> (lo_cnt >= WP_CYC));
    assert_ce_framing_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);
    assert_byte_window_R5: assert property (@(posedge clk) disable iff (rst)
        (fell && seen_q) |-> (gap_cnt >= BLC_CYC && gap_cnt <= BL_MAX_CYC));
    assert_page_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        (fell && seen_q) |-> (mem_addr[ADDR_W-1:IDX_W] == page_q));
    assert_refuse_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> (ack && mem_ce_n));
    assert_ack_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (use_rdy && ack) |-> mem_rdy);
endmodule

bind eep_page_ctrl eep_page_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .WP_CYC     (WP_CYC),
    .BLC_CYC    (BLC_CYC),
    .BL_MAX_CYC (BL_MAX_CYC),
    .RP_CYC     (RP_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .use_rdy  (use_rdy),
    .ack      (ack),
    .err      (err),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_rdy  (mem_rdy),
    .mem_addr (mem_addr)
);

// File: tb/eep_page_ctrl_test.sv
module eep_page_ctrl_test;
    localparam int CLK_NS   = 10;
    localparam int WP_MIN   = 250 / CLK_NS;
    localparam int BLC_MIN  = 1000 / CLK_NS;
    localparam int BLMAX    = 30000 / CLK_NS;
    localparam int RP_MIN   = 100000 / CLK_NS;
    localparam int WC_NS    = 20000;
    localparam int WC_CYC   = WC_NS / CLK_NS;
    localparam int DW_MIN   = 250 / CLK_NS;
    localparam int ACC_MIN  = 250 / CLK_NS;
    localparam int BUSY_DLY = 5;
    localparam int PROG_CYC = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        use_rdy = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [6:0]  wr_idx;
    logic [7:0]  wr_byte;
    logic        ack, err;
    logic [7:0]  rd_data;
    logic        ce_n, oe_n, we_n, mem_rst_n;
    logic [16:0] addr;
    wire  [7:0]  dq;
    logic        rdy = 1'b1;
    logic [7:0]  rd_val = 8'hFF;

    logic [7:0]  hbuf [128];
    logic [7:0]  model_mem [int];
    logic [7:0]  expv [int];
    int          pend_a[$];
    logic [7:0]  pend_d[$];

    int checks = 0, fails = 0;
    int cyc = 0, rel_cyc = 0;
    bit prev_we = 1, prev_ce = 1, prev_oe = 1, in_page = 0, first_pend = 1;
    int oe_lo = 0, we_lo = 0, last_fall = 0, last_rise = 0, ce_falls = 0;
    logic [9:0] page_hi = '0;
    logic [16:0] exp_addr = '0;
    bit prog = 0, busy_seen = 0;
    int busy_at = 0, done_at = 0, commit_cyc = 0;

    assign wr_byte = hbuf[wr_idx];
    assign dq = (!ce_n && !oe_n && we_n) ? rd_val : 8'bz;

    always #(CLK_NS/2) clk = ~clk;

    eep_page_ctrl #(.CLK_PERIOD_NS(CLK_NS), .T_WC_NS(WC_NS)) uut (
        .clk(clk), .rst(rst), .use_rdy(use_rdy), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .ack(ack), .err(err), .rd_data(rd_data), .mem_ce_n(ce_n), .mem_oe_n(oe_n),
        .mem_we_n(we_n), .mem_addr(addr), .mem_dq(dq), .mem_rdy(rdy), .mem_rst_n(mem_rst_n)
    );

    task automatic check(input bit ok, input string rq, input int act, input int expd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d (0x%0h) expected %0d (0x%0h)", rq, act, act, expd, expd);
        end
    endtask

    // Memory model and per-clock protocol comparison
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            check(!(!oe_n && !we_n), "R3 overlap", {30'd0, oe_n, we_n}, 3);
            if (!ce_n && prev_ce) begin
                ce_falls++;
                if (first_pend) begin
                    check(cyc - rel_cyc >= RP_MIN, "R1 first access delay", cyc - rel_cyc, RP_MIN);
                    first_pend = 0;
                end
            end
            if (!oe_n) oe_lo++;
            else if (!prev_oe) begin
                check(oe_lo >= ACC_MIN, "R2 access width", oe_lo, ACC_MIN);
                oe_lo = 0;
            end
            if (!we_n && prev_we) begin
                if (in_page) begin
                    check(cyc - last_fall >= BLC_MIN && cyc - last_fall <= BLMAX,
                          "R5 byte window", cyc - last_fall, BLC_MIN);
                    check(addr[16:7] == page_hi, "R6 page bits", int'(addr[16:7]), int'(page_hi));
                end else begin
                    page_hi = addr[16:7];
                    in_page = 1;
                end
                check(addr == exp_addr, "R6 byte address", int'(addr), int'(exp_addr));
                exp_addr++;
                last_fall = cyc;
                we_lo = 0;
            end
            if (!we_n) we_lo++;
            if (we_n && !prev_we) begin
                check(we_lo >= WP_MIN, "R4 strobe width", we_lo, WP_MIN);
                check(!ce_n, "R4 chip enable", int'(ce_n), 0);
                pend_a.push_back(int'(addr));
                pend_d.push_back(dq);
                last_rise = cyc;
            end
            if (ce_n) in_page = 0;
            if (!prog && pend_a.size() > 0 && cyc - last_rise > BLMAX) begin
                prog = 1;
                busy_at = cyc + BUSY_DLY;
                done_at = busy_at + PROG_CYC;
            end
            if (prog && cyc == busy_at) begin
                rdy = 0;
                busy_seen = 1;
            end
            if (prog && cyc == done_at) begin
                while (pend_a.size() > 0) model_mem[pend_a.pop_front()] = pend_d.pop_front();
                rdy = 1;
                prog = 0;
                commit_cyc = cyc;
            end
            if (ack && use_rdy)
                check(rdy == 1'b1, "R9 ack while busy", int'(rdy), 1);
            rd_val = model_mem.exists(int'(addr)) ? model_mem[int'(addr)] : 8'hFF;
        end
        prev_we = we_n;
        prev_ce = ce_n;
        prev_oe = oe_n;
    end

    task automatic do_read(input logic [16:0] a, output logic [7:0] d, output logic e);
        req = 1; req_write = 0; req_addr = a;
        do @(negedge clk); while (!ack);
        d = rd_data; e = err;
        req = 0;
        @(negedge clk);
        check(!ack, "R2 ack one cycle", int'(ack), 0);
    endtask

    task automatic do_write(input logic [16:0] a, input int len, input int seed,
                            output logic e, output int ack_cyc);
        for (int i = 0; i < 128; i++) hbuf[i] = 8'((i * 37 + seed) ^ (i >> 2));
        exp_addr = a;
        req = 1; req_write = 1; req_addr = a; req_len = 8'(len);
        do @(negedge clk); while (!ack);
        e = err; ack_cyc = cyc;
        req = 0;
        if (!e) for (int i = 0; i < len; i++) expv[int'(a) + i] = hbuf[i];
        @(negedge clk);
    endtask

    task automatic read_check(input logic [16:0] a, input string rq);
        logic [7:0] d; logic e; logic [7:0] x;
        x = expv.exists(int'(a)) ? expv[int'(a)] : 8'hFF;
        do_read(a, d, e);
        check(d == x, rq, int'(d), int'(x));
        check(!e, {rq, " no err"}, int'(e), 0);
    endtask

    initial begin
        logic e; int ac; int cf;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(mem_rst_n == 0, "R1 mem reset", int'(mem_rst_n), 0);
        check(ce_n && oe_n && we_n, "R1 strobes idle", {29'd0, ce_n, oe_n, we_n}, 7);
        check(!ack, "R1 ack low", int'(ack), 0);
        rst = 0; rel_cyc = cyc;
        @(negedge clk);
        check(mem_rst_n == 1, "R1 mem reset released", int'(mem_rst_n), 1);

        // R2 blank read right after reset (also R1 quiet period)
        read_check(17'h00010, "R2 blank read");

        // R8 timeout-mode write of 4 bytes
        use_rdy = 0;
        do_write(17'h01234, 4, 3, e, ac);
        check(!e, "R8 accepted", int'(e), 0);
        check(ac - last_rise >= WC_CYC, "R8 waits programming time", ac - last_rise, WC_CYC);
        check(commit_cyc < ac, "R8 ack after commit", commit_cyc, ac);
        for (int i = 0; i < 4; i++) read_check(17'h01234 + 17'(i), "R10 readback small page");

        // R9 ready-mode full page
        use_rdy = 1; busy_seen = 0;
        do_write(17'h05000, 128, 11, e, ac);
        check(!e, "R9 full page accepted", int'(e), 0);
        check(busy_seen, "R9 busy observed", int'(busy_seen), 1);
        check(ac - commit_cyc >= DW_MIN, "R9 recovery after ready", ac - commit_cyc, DW_MIN);
        read_check(17'h05000, "R10 page first byte");
        read_check(17'h0503F, "R10 page middle byte");
        read_check(17'h0507F, "R10 page last byte");

        // R7 refusals
        cf = ce_falls;
        do_write(17'h0007E, 4, 5, e, ac);
        check(e, "R7 crossing refused", int'(e), 1);
        do_write(17'h00000, 0, 5, e, ac);
        check(e, "R7 zero length refused", int'(e), 1);
        do_write(17'h00000, 129, 5, e, ac);
        check(e, "R7 oversize refused", int'(e), 1);
        check(ce_falls == cf, "R7 no strobe on refusal", ce_falls - cf, 0);
        read_check(17'h0007E, "R7 memory untouched");

        // R7 boundary: ends exactly at page end, timeout mode
        use_rdy = 0;
        do_write(17'h0207C, 4, 29, e, ac);
        check(!e, "R7 page-end write accepted", int'(e), 1'b0);
        read_check(17'h0207C, "R10 boundary first");
        read_check(17'h0207F, "R10 boundary last");
        read_check(17'h02080, "R10 next page untouched");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual %0d expected completion", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule